// File: doc/BRIEF.md
# SDRAM bus trace capture decoder

This block sits beside an SDRAM controller and only listens. On every rising edge of the memory clock it decodes the command pins. It keeps a note of which row each bank has open. When a column command is issued, it pairs the column value with the row held for that bank, so that each read or write data beat becomes a trace record with a complete physical address. The record also carries the data word, the transfer direction and a flag that marks instruction fetches. A debug buffer downstream stores the records. This block stores none of them.

Write data is taken on the same edge as the Write command. Read data is taken a programmable number of edges later, set by the CAS latency input. In both cases a beat becomes a record only if the external data strobe is high on the edge where the beat is due. A column command aimed at a bank with no open row still produces a record, but with an error flag set in place of a rebuilt row.

Top module: `sdram_trace_decoder`

## Requirements
- R1: Commands decode from {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} as follows: 0011 Activate, 0101 Read, 0100 Write, 0010 Precharge, 0001 Refresh. Any other pattern, including every pattern with mem_cs_n high, is treated as Nop.
- R2: An Activate stores mem_addr as the open row of bank mem_bank and marks that bank open.
- R3: A Precharge with mem_addr[10] low closes only the addressed bank. With mem_addr[10] high it closes all four banks.
- R4: A Write makes a beat due on the same edge. Its record address is {bank, open row, mem_addr[8:0]}, with bank in rec_addr[23:22], row in [21:9] and column in [8:0]. rec_write is 1.
- R5: A Read makes a beat due cfg_cas_lat edges later. Values 1 to 3 are valid, and 0 acts as 1. Its address is formed from the row that was open when the Read was issued. rec_write is 0.
- R6: A due beat yields a record only if data_strobe is high on that edge. Otherwise the beat is dropped.
- R7: A record appears with rec_valid high for the one cycle after the edge where it was due. rec_data and rec_code carry mem_data and code_fetch as sampled on that edge. rec_valid is low in every other cycle.
- R8: A column command to a closed bank gives rec_err = 1, with the row field of rec_addr all zero.
- R9: If a Read beat falls due on the same edge as a Write command, the read record is emitted and the write beat is dropped.
- R10: After reset, rec_valid is 0 and every bank is closed.
- R11: Refresh, Nop, deselect and the other non-decoded patterns leave every bank's open row and open flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock; everything is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cas_lat | input | 2 | CAS latency in clock edges (1 to 3) |
| mem_cs_n | input | 1 | Observed chip select, active low |
| mem_ras_n | input | 1 | Observed row strobe, active low |
| mem_cas_n | input | 1 | Observed column strobe, active low |
| mem_we_n | input | 1 | Observed write enable, active low |
| mem_bank | input | 2 | Observed bank address |
| mem_addr | input | 13 | Observed multiplexed row/column address |
| mem_data | input | 32 | Observed data bus |
| data_strobe | input | 1 | High on edges where the data bus may be captured |
| code_fetch | input | 1 | High when the current beat is an instruction fetch |
| rec_valid | output | 1 | One-cycle pulse that marks a record |
| rec_write | output | 1 | 1 for a write beat, 0 for a read beat |
| rec_code | output | 1 | Captured code-fetch flag |
| rec_err | output | 1 | Column command hit a closed bank |
| rec_addr | output | 24 | Physical address: bank, row, column |
| rec_data | output | 32 | Captured data word |

## Verification
Two activities can land on the same clock edge. The first is a read beat coming due after its CAS latency. The second is a new command, either a Write, which competes for the data bus, or an Activate or Precharge that changes the row the read came from. Directed sequences issue a Read and then place a Write, or a Precharge of all banks, exactly cfg_cas_lat edges later, at latencies 2 and 3. Long random runs produce many more of these overlaps. A bench model keeps the row in flight with each queued read. Each record is then judged field by field: the read must win over the write, and its address must use the row that was open when the Read was issued, not the state left by the later command.

// File: rtl/sdtr_pkg.sv
package sdtr_pkg;

    localparam int unsigned SDTR_BANK_W  = 2;
    localparam int unsigned SDTR_ROW_W   = 13;
    localparam int unsigned SDTR_COL_W   = 9;
    localparam int unsigned SDTR_DATA_W  = 32;
    localparam int unsigned SDTR_MAX_CL  = 3;
    localparam int unsigned SDTR_ALL_BIT = 10;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_REF = 3'd5
    } sdtr_cmd_e;

    // Pin group to command; anything unrecognised counts as idle.
    function automatic sdtr_cmd_e sdtr_decode(input logic cs_n, input logic ras_n,
                                              input logic cas_n, input logic we_n);
        sdtr_cmd_e c;
        c = CMD_NOP;
        if (!cs_n) begin
            case ({ras_n, cas_n, we_n})
                3'b011:  c = CMD_ACT;
                3'b101:  c = CMD_RD;
                3'b100:  c = CMD_WR;
                3'b010:  c = CMD_PRE;
                3'b001:  c = CMD_REF;
                default: c = CMD_NOP;
            endcase
        end
        return c;
    endfunction

    function automatic logic sdtr_is_column(input sdtr_cmd_e c);
        return (c == CMD_RD) || (c == CMD_WR);
    endfunction

endpackage

// File: rtl/sdtr_cmd_decode.sv
module sdtr_cmd_decode
    import sdtr_pkg::*;
(
    input  logic      cs_n,
    input  logic      ras_n,
    input  logic      cas_n,
    input  logic      we_n,
    output sdtr_cmd_e cmd
);

    always_comb begin
        cmd = sdtr_decode(cs_n, ras_n, cas_n, we_n);
    end

endmodule

// File: rtl/sdtr_row_track.sv
module sdtr_row_track
    import sdtr_pkg::*;
#(
    parameter int unsigned BANK_W  = SDTR_BANK_W,
    parameter int unsigned ROW_W   = SDTR_ROW_W,
    parameter int unsigned ALL_BIT = SDTR_ALL_BIT,
    localparam int unsigned BANKS  = 1 << BANK_W
) (
    input  logic              clk,
    input  logic              rst,
    input  sdtr_cmd_e         cmd,
    input  logic [BANK_W-1:0] bank,
    input  logic [ROW_W-1:0]  maddr,
    output logic [BANKS-1:0]  row_vld,
    output logic [ROW_W-1:0]  sel_row,
    output logic              sel_hit
);

    logic [BANKS-1:0][ROW_W-1:0] rows;

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic [ROW_W-1:0] row_q;
        logic             vld_q;
        logic             mine;

        assign mine = (bank == BANK_W'(b));

        always_ff @(posedge clk) begin
            if (rst) begin
                row_q <= '0;
                vld_q <= 1'b0;
            end else begin
                case (cmd)
                    CMD_ACT: begin
                        if (mine) begin
                            row_q <= maddr;
                            vld_q <= 1'b1;
                        end
                    end
                    CMD_PRE: begin
                        if (mine || maddr[ALL_BIT]) begin
                            vld_q <= 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
        end

        assign rows[b]    = row_q;
        assign row_vld[b] = vld_q;
    end

    assign sel_row = rows[bank];
    assign sel_hit = row_vld[bank];

endmodule

// File: rtl/sdtr_beat_pipe.sv
module sdtr_beat_pipe
    import sdtr_pkg::*;
#(
    parameter int unsigned BANK_W  = SDTR_BANK_W,
    parameter int unsigned ROW_W   = SDTR_ROW_W,
    parameter int unsigned COL_W   = SDTR_COL_W,
    parameter int unsigned DATA_W  = SDTR_DATA_W,
    parameter int unsigned MAX_CL  = SDTR_MAX_CL,
    localparam int unsigned ADDR_W = BANK_W + ROW_W + COL_W,
    localparam int unsigned CL_W   = $clog2(MAX_CL + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  sdtr_cmd_e         cmd,
    input  logic [BANK_W-1:0] bank,
    input  logic [COL_W-1:0]  col,
    input  logic [ROW_W-1:0]  open_row,
    input  logic              open_hit,
    input  logic [CL_W-1:0]   cas_lat,
    input  logic              strobe,
    input  logic [DATA_W-1:0] mdata,
    input  logic              code,
    output logic              rd_due,
    output logic              rec_valid,
    output logic              rec_write,
    output logic              rec_code,
    output logic              rec_err,
    output logic [ADDR_W-1:0] rec_addr,
    output logic [DATA_W-1:0] rec_data
);

    typedef struct packed {
        logic              v;
        logic              err;
        logic [ADDR_W-1:0] addr;
    } beat_t;

    beat_t           cur;
    beat_t           sel;
    beat_t           pend_q [1:MAX_CL];
    logic [CL_W-1:0] lat;
    logic            due;

    // Column beat as seen on this edge, row taken from the bank tracker now.
    always_comb begin
        cur.v    = sdtr_is_column(cmd);
        cur.err  = !open_hit;
        cur.addr = {bank, (open_hit ? open_row : {ROW_W{1'b0}}), col};
    end

    always_comb begin
        if (cas_lat == '0)
            lat = CL_W'(1);
        else if (cas_lat > CL_W'(MAX_CL))
            lat = CL_W'(MAX_CL);
        else
            lat = cas_lat;
    end

    // Delay line: a read enters at depth lat and falls due when it leaves stage 1.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 1; k <= MAX_CL; k++) pend_q[k] <= '0;
        end else begin
            for (int k = 1; k < MAX_CL; k++) begin
                if (cmd == CMD_RD && lat == CL_W'(k))
                    pend_q[k] <= cur;
                else
                    pend_q[k] <= pend_q[k+1];
            end
            if (cmd == CMD_RD && lat == CL_W'(MAX_CL))
                pend_q[MAX_CL] <= cur;
            else
                pend_q[MAX_CL] <= '0;
        end
    end

    // A maturing read owns the data bus; a simultaneous write beat loses.
    assign rd_due = pend_q[1].v;
    assign sel    = rd_due ? pend_q[1] : cur;
    assign due    = rd_due || (cmd == CMD_WR);

    always_ff @(posedge clk) begin
        if (rst) begin
            rec_valid <= 1'b0;
            rec_write <= 1'b0;
            rec_code  <= 1'b0;
            rec_err   <= 1'b0;
            rec_addr  <= '0;
            rec_data  <= '0;
        end else begin
            rec_valid <= due && strobe;
            if (due && strobe) begin
                rec_write <= !rd_due;
                rec_code  <= code;
                rec_err   <= sel.err;
                rec_addr  <= sel.addr;
                rec_data  <= mdata;
            end
        end
    end

endmodule

// File: rtl/sdram_trace_decoder.sv
module sdram_trace_decoder
    import sdtr_pkg::*;
#(
    parameter int unsigned BANK_W  = SDTR_BANK_W,
    parameter int unsigned ROW_W   = SDTR_ROW_W,
    parameter int unsigned COL_W   = SDTR_COL_W,
    parameter int unsigned DATA_W  = SDTR_DATA_W,
    parameter int unsigned MAX_CL  = SDTR_MAX_CL,
    parameter int unsigned ALL_BIT = SDTR_ALL_BIT,
    localparam int unsigned ADDR_W = BANK_W + ROW_W + COL_W,
    localparam int unsigned CL_W   = $clog2(MAX_CL + 1),
    localparam int unsigned BANKS  = 1 << BANK_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CL_W-1:0]   cfg_cas_lat,
    input  logic              mem_cs_n,
    input  logic              mem_ras_n,
    input  logic              mem_cas_n,
    input  logic              mem_we_n,
    input  logic [BANK_W-1:0] mem_bank,
    input  logic [ROW_W-1:0]  mem_addr,
    input  logic [DATA_W-1:0] mem_data,
    input  logic              data_strobe,
    input  logic              code_fetch,
    output logic              rec_valid,
    output logic              rec_write,
    output logic              rec_code,
    output logic              rec_err,
    output logic [ADDR_W-1:0] rec_addr,
    output logic [DATA_W-1:0] rec_data
);

    sdtr_cmd_e        cmd;
    logic [BANKS-1:0] row_vld;
    logic [ROW_W-1:0] open_row;
    logic             open_hit;
    logic             rd_due;

    sdtr_cmd_decode u_dec (
        .cs_n  (mem_cs_n),
        .ras_n (mem_ras_n),
        .cas_n (mem_cas_n),
        .we_n  (mem_we_n),
        .cmd   (cmd)
    );

    sdtr_row_track #(
        .BANK_W  (BANK_W),
        .ROW_W   (ROW_W),
        .ALL_BIT (ALL_BIT)
    ) u_rows (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .bank    (mem_bank),
        .maddr   (mem_addr),
        .row_vld (row_vld),
        .sel_row (open_row),
        .sel_hit (open_hit)
    );

    sdtr_beat_pipe #(
        .BANK_W (BANK_W),
        .ROW_W  (ROW_W),
        .COL_W  (COL_W),
        .DATA_W (DATA_W),
        .MAX_CL (MAX_CL)
    ) u_pipe (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .bank      (mem_bank),
        .col       (mem_addr[COL_W-1:0]),
        .open_row  (open_row),
        .open_hit  (open_hit),
        .cas_lat   (cfg_cas_lat),
        .strobe    (data_strobe),
        .mdata     (mem_data),
        .code      (code_fetch),
        .rd_due    (rd_due),
        .rec_valid (rec_valid),
        .rec_write (rec_write),
        .rec_code  (rec_code),
        .rec_err   (rec_err),
        .rec_addr  (rec_addr),
        .rec_data  (rec_data)
    );

endmodule

// File: rtl/sdtr_checker.sv
module sdtr_checker
    import sdtr_pkg::*;
#(
    parameter int unsigned BANK_W  = SDTR_BANK_W,
    parameter int unsigned ROW_W   = SDTR_ROW_W,
    parameter int unsigned COL_W   = SDTR_COL_W,
    parameter int unsigned DATA_W  = SDTR_DATA_W,
    parameter int unsigned ALL_BIT = SDTR_ALL_BIT,
    localparam int unsigned ADDR_W = BANK_W + ROW_W + COL_W,
    localparam int unsigned BANKS  = 1 << BANK_W
) (
    input logic              clk,
    input logic              rst,
    input sdtr_cmd_e         cmd,
    input logic [BANK_W-1:0] mem_bank,
    input logic [ROW_W-1:0]  mem_addr,
    input logic [DATA_W-1:0] mem_data,
    input logic              data_strobe,
    input logic [BANKS-1:0]  row_vld,
    input logic              rd_due,
    input logic              rec_valid,
    input logic              rec_write,
    input logic              rec_err,
    input logic [ADDR_W-1:0] rec_addr,
    input logic [DATA_W-1:0] rec_data
);

    AST_ACT_OPENS_BANK: assert property (@(posedge clk) disable iff (rst)
        cmd == CMD_ACT |=> row_vld[$past(mem_bank)]); // R2

    AST_PCH_ALL_CLOSES: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_PRE && mem_addr[ALL_BIT]) |=> row_vld == '0); // R3

    AST_PCH_ONE_CLOSES: assert property (@(posedge clk) disable iff (rst)
        cmd == CMD_PRE |=> !row_vld[$past(mem_bank)]); // R3

    AST_IDLE_KEEPS_ROWS: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_NOP || cmd == CMD_REF) |=> $stable(row_vld)); // R11

    AST_STROBE_GATES: assert property (@(posedge clk) disable iff (rst)
        rec_valid |-> $past(data_strobe)); // R6

    AST_DATA_FROM_BUS: assert property (@(posedge clk) disable iff (rst)
        rec_valid |-> rec_data == $past(mem_data)); // R7

    AST_ERR_ROW_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && rec_err) |-> rec_addr[COL_W +: ROW_W] == '0); // R8

    AST_READ_WINS_BUS: assert property (@(posedge clk) disable iff (rst)
        (rd_due && cmd == CMD_WR && data_strobe) |=> (rec_valid && !rec_write)); // R9

endmodule

bind sdram_trace_decoder sdtr_checker #(
    .BANK_W  (BANK_W),
    .ROW_W   (ROW_W),
    .COL_W   (COL_W),
    .DATA_W  (DATA_W),
    .ALL_BIT (ALL_BIT)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cmd         (cmd),
    .mem_bank    (mem_bank),
    .mem_addr    (mem_addr),
    .mem_data    (mem_data),
    .data_strobe (data_strobe),
    .row_vld     (row_vld),
    .rd_due      (rd_due),
    .rec_valid   (rec_valid),
    .rec_write   (rec_write),
    .rec_err     (rec_err),
    .rec_addr    (rec_addr),
    .rec_data    (rec_data)
);

// File: tb/sim_sdram_trace_decoder.sv
`timescale 1ns/1ps
module sim_sdram_trace_decoder;

    typedef enum int {K_NOP, K_ACT, K_RD, K_WR, K_PRE, K_REF, K_DES, K_MRS, K_BST} kind_e;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cfg_cas_lat = 2'd2;
    logic        mem_cs_n = 1'b1, mem_ras_n = 1'b1, mem_cas_n = 1'b1, mem_we_n = 1'b1;
    logic [1:0]  mem_bank = '0;
    logic [12:0] mem_addr = '0;
    logic [31:0] mem_data = '0;
    logic        data_strobe = 1'b0;
    logic        code_fetch = 1'b0;
    logic        rec_valid, rec_write, rec_code, rec_err;
    logic [23:0] rec_addr;
    logic [31:0] rec_data;

    always #4 clk = ~clk;

    sdram_trace_decoder u0 (
        .clk(clk), .rst(rst), .cfg_cas_lat(cfg_cas_lat),
        .mem_cs_n(mem_cs_n), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n),
        .mem_bank(mem_bank), .mem_addr(mem_addr), .mem_data(mem_data),
        .data_strobe(data_strobe), .code_fetch(code_fetch),
        .rec_valid(rec_valid), .rec_write(rec_write), .rec_code(rec_code), .rec_err(rec_err),
        .rec_addr(rec_addr), .rec_data(rec_data)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int cl     = 2;

    // Reference state: open rows and queued read beats keyed by due cycle.
    bit [12:0] m_row [4];
    bit        m_vld [4];
    bit        r_v   [8];
    bit        r_err [8];
    bit [23:0] r_addr[8];

    bit        e_v, e_w, e_c, e_e;
    bit [23:0] e_a;
    bit [31:0] e_d;
    string     e_tag = "R10";

    task automatic compare();
        bit bad;
        checks++;
        bad = (rec_valid !== e_v);
        if (e_v && ({rec_write, rec_code, rec_err, rec_addr, rec_data} !== {e_w, e_c, e_e, e_a, e_d}))
            bad = 1'b1;
        if (bad) begin
            fails++;
            $display("FAIL %s: got v=%b w=%b c=%b e=%b a=%h d=%h, expected v=%b w=%b c=%b e=%b a=%h d=%h",
                     e_tag, rec_valid, rec_write, rec_code, rec_err, rec_addr, rec_data,
                     e_v, e_w, e_c, e_e, e_a, e_d);
        end
    endtask

    task automatic model(kind_e k, int b, bit [12:0] a, bit stb, bit [31:0] d, bit cf);
        int        slot;
        bit        hit;
        bit [23:0] wa;
        slot = cyc % 8;
        hit  = m_vld[b];
        wa   = {2'(b), (hit ? m_row[b] : 13'h0), a[8:0]};
        e_v = 0; e_tag = "R7";
        if (r_v[slot]) begin
            // R5 read beat due now; R9 it beats a same-edge write
            e_v = stb; e_w = 0; e_e = r_err[slot]; e_a = r_addr[slot];
            e_tag = (k == K_WR) ? "R9" : (r_err[slot] ? "R8" : "R5");
            if (!stb) e_tag = "R6";
            r_v[slot] = 0;
        end else if (k == K_WR) begin
            e_v = stb; e_w = 1; e_e = !hit; e_a = wa;
            e_tag = !stb ? "R6" : (!hit ? "R8" : "R4");
        end
        e_d = d; e_c = cf;
        if (k == K_RD) begin
            int s;
            s = (cyc + cl) % 8;
            r_v[s] = 1; r_err[s] = !hit; r_addr[s] = wa;
        end
        if (k == K_ACT) begin m_row[b] = a; m_vld[b] = 1; end
        if (k == K_PRE) begin
            if (a[10]) begin
                for (int i = 0; i < 4; i++) m_vld[i] = 0;
            end else m_vld[b] = 0;
        end
    endtask

    // R1 pin patterns per command
    task automatic step(kind_e k, int b, bit [12:0] a, bit stb = 1'b1);
        bit [31:0] d;
        bit        cf;
        d  = $urandom;
        cf = 1'($urandom);
        @(negedge clk);
        compare();
        case (k)
            K_ACT:   {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} = 4'b0011;
            K_RD:    {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} = 4'b0101;
            K_WR:    {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} = 4'b0100;
            K_PRE:   {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} = 4'b0010;
            K_REF:   {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} = 4'b0001;
            K_DES:   {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} = 4'b1000;
            K_MRS:   {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} = 4'b0000;
            K_BST:   {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} = 4'b0110;
            default: {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} = 4'b0111;
        endcase
        mem_bank    = 2'(b);
        mem_addr    = a;
        data_strobe = stb;
        mem_data    = d;
        code_fetch  = cf;
        cfg_cas_lat = 2'(cl);
        model(k, b, a, stb, d, cf);
        cyc++;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(K_NOP, 0, 13'h0);
    endtask

    task automatic random_run(int n);
        for (int i = 0; i < n; i++) begin
            int        r;
            kind_e     k;
            bit [12:0] a;
            r = $urandom % 16;
            a = 13'($urandom);
            if (r < 3) k = K_ACT;
            else if (r < 7) k = K_RD;
            else if (r < 10) k = K_WR;
            else if (r < 12) k = K_PRE;
            else if (r == 12) k = K_REF;
            else if (r == 13) k = K_NOP;
            else if (r == 14) k = K_DES;
            else k = ($urandom % 2) ? K_MRS : K_BST;
            if (k == K_PRE && ($urandom % 4) != 0) a[10] = 1'b0;
            step(k, int'($urandom % 4), a, ($urandom % 10) != 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got no finish, expected end of run");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_c0de));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10: no record after reset, and every bank starts closed
        step(K_RD, 1, 13'h012);
        idle(3);                                   // R8 error record at CL 2
        // R2 / R4: open bank 0, write then read the same page
        step(K_ACT, 0, 13'h1A5);
        step(K_WR, 0, 13'h033);
        step(K_RD, 0, 13'h1FF);
        idle(3);
        // R3: single-bank precharge spares the other bank
        step(K_ACT, 2, 13'h0F0);
        step(K_PRE, 0, 13'h000);
        step(K_RD, 2, 13'h004);
        step(K_RD, 0, 13'h005);
        idle(3);
        // R3: precharge-all while a read of bank 2 is due (row taken at command time)
        step(K_ACT, 1, 13'h0AA);
        step(K_ACT, 3, 13'h155);
        step(K_RD, 2, 13'h007);
        step(K_NOP, 0, 13'h0);
        step(K_PRE, 0, 13'h400);
        step(K_WR, 1, 13'h009);                    // R8 after close
        idle(2);
        // R11 / R1: idle patterns keep the open row
        step(K_ACT, 3, 13'h1C3);
        step(K_REF, 3, 13'h400);
        step(K_DES, 3, 13'h400);
        step(K_MRS, 3, 13'h400);
        step(K_BST, 3, 13'h400);
        step(K_WR, 3, 13'h011);
        idle(2);
        // R9: write lands on the edge the read beat matures
        step(K_RD, 3, 13'h021);
        step(K_NOP, 0, 13'h0);
        step(K_WR, 3, 13'h022);
        idle(3);
        // R6: strobe low on the due edge drops the beat
        step(K_RD, 3, 13'h031);
        step(K_NOP, 0, 13'h0);
        step(K_NOP, 0, 13'h0, 1'b0);
        step(K_WR, 3, 13'h032, 1'b0);
        idle(3);
        random_run(1500);
        idle(4);
        // R5 at CL 3, directed then random
        cl = 3;
        idle(1);
        step(K_ACT, 0, 13'h0BE);
        step(K_RD, 0, 13'h0EF);
        step(K_NOP, 0, 13'h0);
        step(K_NOP, 0, 13'h0);
        step(K_WR, 0, 13'h0F1);                    // R9 at CL 3
        idle(4);
        random_run(1500);
        idle(5);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule